// File: doc/BRIEF.md
# Watchdog Timer with Pre-Timeout Warning

This block is a watchdog timer controlled through one 32-bit register. Software picks a prescaler code and an interval code, enables the timer and then has to keep restarting it. If the interval runs out, the block has two stages. First it raises a sticky interrupt flag and drives its interrupt output. Then a fixed grace window runs, and if software still has not restarted the count, the block issues a one-cycle system reset request. When the interrupt is disabled, the reset request follows expiry directly.

Counting advances only on clock cycles where the tick-enable input is high. Software restarts the count with a read-modify-write that sets the self-clearing restart bit and leaves every other field as it was. Writing zero to the whole register stops the timer. Both status flags are write-one-to-clear. The reset flag outlives the request, so software can later read why the reset happened.

Top module: `wdog_pretimeout`

## Requirements
- R1: After reset `rdData` reads 0, and `irqOut` and `rstReqOut` are low.
- R2: The register fields are: bits 11:10 prescaler code, bit 7 run, bit 6 interrupt enable, bits 5:4 interval code, bit 3 interrupt flag, bit 2 reset flag, bit 1 reset enable, bit 0 restart. `wrStrb[0]` writes bits 7:0 and `wrStrb[1]` writes bits 11:10. Bit 0 and every unlisted bit read 0.
- R3: After a restart edge, expiry occurs exactly P*L counted ticks later, where P = 2^(2+2*prescaler code) and L = 2^(4+2*interval code) with the default parameters. Each code step therefore multiplies the timeout by 4.
- R4: When the timer expires with interrupt enable set, the interrupt flag is set on the expiry edge. `irqOut` is the flag ANDed with interrupt enable.
- R5: The grace window is 1024 prescaled ticks and starts at an expiry that raised the interrupt. If it ends with no restart and reset enable is set, `rstReqOut` goes high for exactly one cycle and the reset flag is set.
- R6: If interrupt enable is clear and reset enable is set, `rstReqOut` pulses on the expiry edge itself, and the interrupt flag stays 0.
- R7: While reset enable is clear, `rstReqOut` is never asserted and the reset flag is never set.
- R8: A restart clears the prescaler, interval and grace counters. Periodic keepalive writes therefore keep expiry from occurring, and expiry then falls a full period after the last restart.
- R9: Writing 1 to bit 3 or bit 2 clears that flag, and writing 0 leaves it unchanged. The reset flag stays set after the reset pulse.
- R10: Writing 0 with all byte strobes stops the timer. Bit 7 then reads 0, and no expiry, interrupt or reset follows.
- R11: Changing the prescaler or interval code while the timer runs, without a restart, does not alter the expiry of the count in progress. The new codes apply from the next restart.
- R12: The counters advance only on cycles where `tickEn` is high. With `tickEn` high on alternate cycles, the timeout in clock cycles doubles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Counting tick qualifier |
| wrEn | input | 1 | Register write strobe |
| wrStrb | input | 4 | Byte enables for the write |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Current register value |
| irqOut | output | 1 | Pre-timeout interrupt |
| rstReqOut | output | 1 | One-cycle system reset request |

## Verification
A counter that is off by one, or a prescaler or interval code decoded wrongly, moves the rising edge of `irqOut` away from the exact cycle that P*L predicts. That shift shows up on the first expiry after a restart. A mistake in the phase sequencing produces one of three visible errors: a reset pulse that comes early or fires without a preceding interrupt, a pulse that lasts longer than one cycle, or an event after a stop. Each of these is caught at the cycle it happens, because every interrupt rise and every reset pulse is compared against a queue of predicted events. Flag and field corruption shows in `rdData` on the next register read.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int REG_W      = 32;
  localparam int BIT_RESTART = 0;
  localparam int BIT_RSTEN   = 1;
  localparam int BIT_RSTFLAG = 2;
  localparam int BIT_IRQFLAG = 3;
  localparam int BIT_IVL_LO  = 4;
  localparam int BIT_IRQEN   = 6;
  localparam int BIT_RUN     = 7;
  localparam int BIT_DIV_LO  = 10;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_COUNT = 2'd1,
    PH_GRACE = 2'd2,
    PH_DONE  = 2'd3
  } phase_t;

  // control -> datapath strobes
  typedef struct packed {
    logic       clear;
    logic       runIvl;
    logic       runGrace;
    logic [1:0] divSel;
    logic [1:0] ivlSel;
  } dpCmd_t;

  // datapath -> control events
  typedef struct packed {
    logic expire;
    logic graceEnd;
  } dpEvt_t;
endpackage

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int PRE_BASE    = 2,
  parameter int PRE_STEP    = 2,
  parameter int IVL_BASE    = 4,
  parameter int GRACE_TICKS = 1024
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   tickEn,
  input  dpCmd_t cmd,
  output dpEvt_t evt
);
  localparam int IVL_STEP = 2;
  localparam int PRE_W    = PRE_BASE + 3 * PRE_STEP + 1;
  localparam int IVL_W    = IVL_BASE + 3 * IVL_STEP + 1;
  localparam int GR_W     = $clog2(GRACE_TICKS) + 1;
  localparam logic [GR_W-1:0] GR_LAST = GR_W'(GRACE_TICKS - 1);

  logic [PRE_W-1:0] preLastTab [4];
  logic [IVL_W-1:0] ivlLastTab [4];

  for (genvar c = 0; c < 4; c++) begin : g_lim
    assign preLastTab[c] = PRE_W'((64'd1 << (PRE_BASE + PRE_STEP * c)) - 64'd1);
    assign ivlLastTab[c] = IVL_W'((64'd1 << (IVL_BASE + IVL_STEP * c)) - 64'd1);
  end

  logic [PRE_W-1:0] preCnt, preLast;
  logic [IVL_W-1:0] ivlCnt, ivlLast;
  logic [GR_W-1:0]  graceCnt;
  logic             active, preTick;

  assign preLast = preLastTab[cmd.divSel];
  assign ivlLast = ivlLastTab[cmd.ivlSel];
  assign active  = cmd.runIvl | cmd.runGrace;
  assign preTick = tickEn & active & (preCnt == preLast);

  assign evt.expire   = preTick & cmd.runIvl & (ivlCnt == ivlLast);
  assign evt.graceEnd = preTick & cmd.runGrace & (graceCnt == GR_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  preCnt <= '0;
    else if (cmd.clear)         preCnt <= '0;
    else if (tickEn && active)  preCnt <= preTick ? '0 : preCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       ivlCnt <= '0;
    else if (cmd.clear)              ivlCnt <= '0;
    else if (preTick && cmd.runIvl)  ivlCnt <= evt.expire ? '0 : ivlCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          graceCnt <= '0;
    else if (cmd.clear || !cmd.runGrace) graceCnt <= '0;
    else if (preTick)                   graceCnt <= graceCnt + 1'b1;
  end

  // R11: the active prescale limit cannot move underneath a running count
  assert_prescale_bound_R11: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (preCnt <= preLast));
  // R5: expiry and grace end are separate phases
  assert_evt_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(evt.expire && evt.graceEnd));
  // R12: counters hold when no tick is qualified
  assert_tick_gate_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !cmd.clear) |=> $stable(preCnt));
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [3:0]  wrStrb,
  input  logic [31:0] wrData,
  input  dpEvt_t      evt,
  output dpCmd_t      cmd,
  output logic [31:0] rdData,
  output logic        irqOut,
  output logic        rstReqOut
);
  logic [1:0] divReg, ivlReg, actDiv, actIvl;
  logic       runReg, irqEnReg, rstEnReg, irqFlag, rstFlag, rstReq;
  phase_t     phase, phaseNext;

  logic       wrLo, wrHi, restartW;
  logic [1:0] divNext, ivlNext;
  logic       runNext, irqEnNext, rstEnNext;
  logic       setIrq, fireRst;
  logic       unusedBits;

  assign unusedBits = ^{wrData[31:12], wrData[9:8], wrStrb[3:2]};

  assign wrLo      = wrEn & wrStrb[0];
  assign wrHi      = wrEn & wrStrb[1];
  assign restartW  = wrLo & wrData[BIT_RESTART];
  assign divNext   = wrHi ? wrData[BIT_DIV_LO +: 2] : divReg;
  assign ivlNext   = wrLo ? wrData[BIT_IVL_LO +: 2] : ivlReg;
  assign runNext   = wrLo ? wrData[BIT_RUN]   : runReg;
  assign irqEnNext = wrLo ? wrData[BIT_IRQEN] : irqEnReg;
  assign rstEnNext = wrLo ? wrData[BIT_RSTEN] : rstEnReg;

  always_comb begin
    phaseNext = phase;
    if (!runNext)       phaseNext = PH_IDLE;
    else if (restartW)  phaseNext = PH_COUNT;
    else begin
      unique case (phase)
        PH_IDLE:  phaseNext = PH_COUNT;
        PH_COUNT: if (evt.expire)   phaseNext = irqEnReg ? PH_GRACE : PH_DONE;
        PH_GRACE: if (evt.graceEnd) phaseNext = PH_DONE;
        default:  phaseNext = PH_DONE;
      endcase
    end
  end

  assign setIrq  = runNext & ~restartW & (phase == PH_COUNT) & evt.expire & irqEnReg;
  assign fireRst = runNext & ~restartW & rstEnReg &
                   (((phase == PH_COUNT) & evt.expire & ~irqEnReg) |
                    ((phase == PH_GRACE) & evt.graceEnd));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divReg   <= '0;
      ivlReg   <= '0;
      actDiv   <= '0;
      actIvl   <= '0;
      runReg   <= 1'b0;
      irqEnReg <= 1'b0;
      rstEnReg <= 1'b0;
      irqFlag  <= 1'b0;
      rstFlag  <= 1'b0;
      rstReq   <= 1'b0;
      phase    <= PH_IDLE;
    end else begin
      divReg   <= divNext;
      ivlReg   <= ivlNext;
      runReg   <= runNext;
      irqEnReg <= irqEnNext;
      rstEnReg <= rstEnNext;
      phase    <= phaseNext;
      rstReq   <= fireRst;
      if (restartW || phase == PH_IDLE) begin
        actDiv <= divNext;
        actIvl <= ivlNext;
      end
      if (setIrq)                           irqFlag <= 1'b1;
      else if (wrLo && wrData[BIT_IRQFLAG]) irqFlag <= 1'b0;
      if (fireRst)                          rstFlag <= 1'b1;
      else if (wrLo && wrData[BIT_RSTFLAG]) rstFlag <= 1'b0;
    end
  end

  assign cmd.clear    = restartW | ~runNext | (phase == PH_IDLE) | (phase == PH_DONE);
  assign cmd.runIvl   = (phase == PH_COUNT);
  assign cmd.runGrace = (phase == PH_GRACE);
  assign cmd.divSel   = actDiv;
  assign cmd.ivlSel   = actIvl;

  always_comb begin
    rdData = '0;
    rdData[BIT_DIV_LO +: 2] = divReg;
    rdData[BIT_RUN]         = runReg;
    rdData[BIT_IRQEN]       = irqEnReg;
    rdData[BIT_IVL_LO +: 2] = ivlReg;
    rdData[BIT_IRQFLAG]     = irqFlag;
    rdData[BIT_RSTFLAG]     = rstFlag;
    rdData[BIT_RSTEN]       = rstEnReg;
  end

  assign irqOut    = irqFlag & irqEnReg;
  assign rstReqOut = rstReq;

  assert_rst_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq);
  assert_rst_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> rstFlag);
  assert_stopped_R10: assert property (@(posedge clk) disable iff (!rstN)
    !runReg |-> (phase == PH_IDLE && !rstReq));
  assert_irq_needs_en_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> $past(irqEnReg));
  assert_restart_R8: assert property (@(posedge clk) disable iff (!rstN)
    (restartW && runNext) |=> (phase == PH_COUNT));
  assert_no_rst_R7: assert property (@(posedge clk) disable iff (!rstN)
    !rstEnReg |=> !rstReq);
endmodule

// File: rtl/wdog_pretimeout.sv
module wdog_pretimeout
  import wdog_pkg::*;
#(
  parameter int PRE_BASE    = 2,
  parameter int PRE_STEP    = 2,
  parameter int IVL_BASE    = 4,
  parameter int GRACE_TICKS = 1024
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  logic        wrEn,
  input  logic [3:0]  wrStrb,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        irqOut,
  output logic        rstReqOut
);
  dpCmd_t cmd;
  dpEvt_t evt;

  wdog_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrStrb    (wrStrb),
    .wrData    (wrData),
    .evt       (evt),
    .cmd       (cmd),
    .rdData    (rdData),
    .irqOut    (irqOut),
    .rstReqOut (rstReqOut)
  );

  wdog_dp #(
    .PRE_BASE    (PRE_BASE),
    .PRE_STEP    (PRE_STEP),
    .IVL_BASE    (IVL_BASE),
    .GRACE_TICKS (GRACE_TICKS)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .tickEn (tickEn),
    .cmd    (cmd),
    .evt    (evt)
  );
endmodule

// File: tb/wdog_pretimeout_tb_top.sv
module wdog_pretimeout_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int GRACE      = 1024;
  localparam int EV_IRQ     = 0;
  localparam int EV_RST     = 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b1;
  logic        wrEn = 1'b0;
  logic [3:0]  wrStrb = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irqOut, rstReqOut;

  int    cyc = 0;
  int    checks = 0;
  int    failures = 0;
  int    lastEdge = 0;
  bit    halfMode = 1'b0;
  bit    done = 1'b0;
  logic  irqPrev = 1'b0;
  logic  rstPrev = 1'b0;

  int    qKind[$];
  int    qCyc[$];
  string qReq[$];

  wdog_pretimeout dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrStrb(wrStrb),
    .wrData(wrData), .rdData(rdData), .irqOut(irqOut), .rstReqOut(rstReqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) tickEn <= halfMode ? cyc[0] : 1'b1;

  function automatic int ticksFor(input int dv, input int iv);
    return (1 << (2 + 2*dv)) * (1 << (4 + 2*iv));
  endfunction

  task automatic checkEq(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    wrEn = 1'b1; wrData = d; wrStrb = s;
    @(posedge clk);
    #1;
    lastEdge = cyc;
    wrEn = 1'b0; wrStrb = '0;
  endtask

  task automatic expectEvt(input int kind, input int at, input string req);
    qKind.push_back(kind);
    qCyc.push_back(at);
    qReq.push_back(req);
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor
  task automatic seeEvt(input int kind);
    int ek, ec;
    string er;
    checks++;
    if (qKind.size() == 0) begin
      failures++;
      $display("FAIL unexpected event kind=%0d at cycle %0d actual=event expected=none", kind, cyc);
    end else begin
      ek = qKind.pop_front();
      ec = qCyc.pop_front();
      er = qReq.pop_front();
      if (ek != kind || ec != cyc) begin
        failures++;
        $display("FAIL %s actual kind=%0d cycle=%0d expected kind=%0d cycle=%0d",
                 er, kind, cyc, ek, ec);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (irqOut && !irqPrev) seeEvt(EV_IRQ);
      if (rstReqOut) seeEvt(EV_RST);
      if (rstReqOut && rstPrev) begin
        checks++; failures++;
        $display("FAIL R5 reset pulse width actual>1 expected=1");
      end
    end
    irqPrev <= irqOut;
    rstPrev <= rstReqOut;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int e, t;
    logic [31:0] v;
    waitCycles(3);
    // R1 reset state
    checkEq(rdData, 32'h0, "R1 rdData");
    checkEq({31'b0, irqOut}, 32'h0, "R1 irqOut");
    checkEq({31'b0, rstReqOut}, 32'h0, "R1 rstReqOut");
    @(negedge clk); rstN = 1'b1;
    waitCycles(2);

    // R2 field layout and byte strobes
    regWrite(32'h0000_0C32, 4'b0011); waitCycles(1);
    checkEq(rdData, 32'h0000_0C32, "R2 full write readback");
    regWrite(32'h0000_0000, 4'b0001); waitCycles(1);
    checkEq(rdData, 32'h0000_0C00, "R2 byte0 only keeps divider");
    regWrite(32'h0, 4'b1111); waitCycles(1);
    checkEq(rdData, 32'h0, "R10 all-zero write");

    // R3 R4 R5: interrupt then reset after grace
    regWrite(32'h0000_00C3, 4'b0001);
    e = lastEdge; t = ticksFor(0, 0);
    expectEvt(EV_IRQ, e + t, "R4 irq at expiry");
    expectEvt(EV_RST, e + t + 4*GRACE, "R5 reset after grace");
    waitCycles(1);
    checkEq(rdData, 32'h0000_00C2, "R2 restart reads 0");
    waitCycles(t + 4*GRACE + 10);
    checkEq(rdData, 32'h0000_00CE, "R5 both flags set");
    checkEq({31'b0, irqOut}, 32'h1, "R4 irqOut high");
    // R9 write-one-to-clear
    regWrite(32'h0000_00C2, 4'b0001); waitCycles(1);
    checkEq(rdData, 32'h0000_00CE, "R9 zero write keeps flags");
    regWrite(32'h0000_00CA, 4'b0001); waitCycles(1);
    checkEq(rdData, 32'h0000_00C6, "R9 clear irq flag, reset flag persists");
    checkEq({31'b0, irqOut}, 32'h0, "R9 irqOut cleared");
    regWrite(32'h0000_0004, 4'b0001); waitCycles(1);
    checkEq(rdData, 32'h0, "R9 clear reset flag");

    // R3 scaling across codes, reset enable clear (R7)
    for (int k = 0; k < 5; k++) begin
      int dv, iv;
      dv = (k < 2) ? 0 : ((k < 4) ? 1 : 2);
      iv = (k == 0) ? 1 : ((k == 1) ? 2 : ((k == 3) ? 1 : 0));
      regWrite(32'h0000_00C1 | (dv << 10) | (iv << 4), 4'b0011);
      e = lastEdge; t = ticksFor(dv, iv);
      expectEvt(EV_IRQ, e + t, "R3 interval scaling");
      waitCycles(t + 5);
      checkEq({31'b0, irqOut}, 32'h1, "R3 irq after scaled period");
      if (k == 0) begin
        waitCycles(4*GRACE + 10);
        checkEq(rdData & 32'h4, 32'h0, "R7 no reset flag without reset enable");
      end
      regWrite(32'h0000_0008, 4'b0011);
      waitCycles(2);
    end

    // R6 reset without interrupt
    regWrite(32'h0000_0083, 4'b0001);
    e = lastEdge;
    expectEvt(EV_RST, e + ticksFor(0, 0), "R6 reset at expiry");
    waitCycles(80);
    checkEq(rdData, 32'h0000_0086, "R6 reset flag only");
    regWrite(32'h0000_0004, 4'b0001);

    // R8 keepalive by read-modify-write
    regWrite(32'h0000_00C3, 4'b0001);
    for (int k = 0; k < 3; k++) begin
      waitCycles(40);
      v = rdData;
      regWrite(v | 32'h1, 4'b1111);
    end
    e = lastEdge;
    expectEvt(EV_IRQ, e + ticksFor(0, 0), "R8 expiry after last restart");
    waitCycles(70);
    checkEq({31'b0, irqOut}, 32'h1, "R8 irq after keepalives stop");
    regWrite(32'h0000_0008, 4'b0011);

    // R11 field change mid-count
    regWrite(32'h0000_00C1, 4'b0011);
    e = lastEdge;
    expectEvt(EV_IRQ, e + ticksFor(0, 0), "R11 old codes keep running");
    waitCycles(10);
    regWrite(32'h0000_0CF0, 4'b0011);
    waitCycles(60);
    checkEq({31'b0, irqOut}, 32'h1, "R11 irq at original period");
    regWrite(32'h0000_00F9, 4'b0011);
    e = lastEdge;
    expectEvt(EV_IRQ, e + ticksFor(0, 3), "R11 new codes from restart");
    waitCycles(ticksFor(0, 3) + 5);
    checkEq({31'b0, irqOut}, 32'h1, "R11 irq at new period");
    regWrite(32'h0000_0008, 4'b0011);

    // R12 alternate-cycle ticks
    halfMode = 1'b1;
    waitCycles(2);
    regWrite(32'h0000_00C1, 4'b0011);
    e = lastEdge;
    expectEvt(EV_IRQ, e + 2*ticksFor(0, 0) - (e % 2), "R12 half-rate ticks");
    waitCycles(140);
    checkEq({31'b0, irqOut}, 32'h1, "R12 irq after doubled time");
    regWrite(32'h0000_0008, 4'b0011);
    halfMode = 1'b0;

    // R10 stop mid-count
    regWrite(32'h0000_00C3, 4'b0001);
    waitCycles(30);
    regWrite(32'h0, 4'b1111);
    waitCycles(100);
    checkEq(rdData, 32'h0, "R10 stopped, run bit 0");
    checkEq({30'b0, irqOut, rstReqOut}, 32'h0, "R10 no events after stop");

    checkEq(qKind.size(), 32'h0, "R3 all predicted events seen");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule